// File: doc/BRIEF.md
# Privilege-Tiered Load/Store Access Gate

This block sits between a core's load/store unit and the on-chip bus. Every request arrives with a 2-bit access class, and the block compares that class with the privilege tier taken from the status word's I/O mode field. A permitted request passes to the bus unchanged. A blocked request is consumed at once and never reaches the bus. A read that is blocked returns zero. One cycle later a trap pulse fires, and it carries a code that names the class that was refused.

The block also polices commands that change the interrupt-enable state. The lowest tier has no control over interrupts. The supervisor tier has full control. The middle tier can mask interrupts only for a bounded time. When that tier masks interrupts, a down-counter loads from a programmable limit. If the counter runs out before anything unmasks them, the block unmasks interrupts itself and sets a watchdog flag.

Requests use a valid/ready handshake. A request is taken in any cycle where `req_valid` and `req_ready` are both high. For a permitted request, `req_ready` follows `bus_ready`, so back-pressure from the bus reaches the core with no added latency. A blocked request sees `req_ready` high at once and never stalls. The request fields must stay stable while `req_valid` is high and `req_ready` is low.

Top module: `priv_access_gate`

## Requirements
- R1: The I/O mode field maps as follows: 2'b00 and 2'b11 select the lowest user tier, 2'b01 selects the middle user tier, and 2'b10 selects supervisor.
- R2: In the lowest tier, only class 0 (ordinary memory) is forwarded. Class 1 (open peripheral), class 2 (guarded peripheral) and class 3 (system register) are blocked.
- R3: In the middle tier, classes 0 and 1 are forwarded and classes 2 and 3 are blocked.
- R4: In the supervisor tier, every class is forwarded.
- R5: For a forwarded request, `bus_valid` equals `req_valid`, `req_ready` equals `bus_ready`, and the write flag, address and data are passed through. For a blocked request, `bus_valid` stays low and `req_ready` is high in the same cycle.
- R6: A blocked read returns zero on `rsp_rdata`. A blocked write leaves its target unchanged, and a later permitted read of that address shows this.
- R7: `trap_pulse` is high for exactly the one cycle that follows each accepted blocked request. `trap_code` then holds that request's class (1, 2 or 3) until the next trap. Both are 0 after reset.
- R8: In the lowest tier, interrupt-enable commands have no effect on `ie_state`, on the timer or on `ie_wd_flag`.
- R9: In the middle tier, a disable command (`ie_cmd_on`=0) issued while interrupts are enabled drops `ie_state` for exactly max(`ie_limit`,1) cycles. After that, `ie_state` returns to 1 and `ie_wd_flag` sets, unless an enable command has arrived first. A disable command issued while interrupts are already disabled is ignored and does not extend the window.
- R10: In the supervisor tier, enable and disable take effect on the next edge, run no timer, and clear `ie_wd_flag`. An enable from the middle or supervisor tier stops a running timer. When a command and timer expiry fall on the same edge, the command wins.
- R11: After reset, `ie_state` is 1 and `ie_wd_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psw_iomode | input | 2 | I/O mode field from the status word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_class | input | 2 | Access class 0..3 |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Read data in the handshake cycle, zero when blocked |
| bus_valid | output | 1 | Bus strobe |
| bus_ready | input | 1 | Bus ready |
| bus_write | output | 1 | Bus write flag |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| trap_pulse | output | 1 | Protection trap, one cycle |
| trap_code | output | 2 | Class of the last blocked access |
| ie_cmd_valid | input | 1 | Interrupt-enable command strobe |
| ie_cmd_on | input | 1 | 1 = enable, 0 = disable |
| ie_limit | input | TW | Middle-tier disable window in cycles |
| ie_state | output | 1 | Current interrupt-enable state |
| ie_wd_flag | output | 1 | Timer expiry forced re-enable |

## Verification
The grant decision, `bus_valid`, `req_ready` and `rsp_rdata` are combinational, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples these outputs 1 ns later, before the rising edge. `trap_pulse`, `trap_code`, `ie_state` and `ie_wd_flag` are registered and change on the rising edge that takes the request or command. The bench updates its own model at that edge and compares at the following falling edge. Expiry is due max(limit,1) edges after the disable edge, and the model counts those edges itself.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  typedef enum logic [1:0] {
    LVL_USER0 = 2'b00,
    LVL_USER1 = 2'b01,
    LVL_SUPER = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    CLS_MEM      = 2'd0,
    CLS_OPEN_IO  = 2'd1,
    CLS_GUARD_IO = 2'd2,
    CLS_SYSREG   = 2'd3
  } cls_e;

  // reserved encoding 2'b11 falls back to the least privileged tier
  function automatic lvl_e decode_lvl(input logic [1:0] field);
    case (field)
      2'b01:   return LVL_USER1;
      2'b10:   return LVL_SUPER;
      default: return LVL_USER0;
    endcase
  endfunction
endpackage

// File: rtl/pgate_rules.sv
module pgate_rules
  import pgate_pkg::*;
(
  input  logic [1:0] iomode,
  input  logic [1:0] cls,
  output lvl_e       lvl,
  output logic       permit
);
  always_comb begin
    lvl = decode_lvl(iomode);
    unique case (lvl)
      LVL_SUPER: permit = 1'b1;
      LVL_USER1: permit = (cls == CLS_MEM) || (cls == CLS_OPEN_IO);
      default:   permit = (cls == CLS_MEM);
    endcase
  end
endmodule

// File: rtl/pgate_trap.sv
module pgate_trap (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blocked_take,
  input  logic [1:0] cls,
  output logic       trap_pulse,
  output logic [1:0] trap_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_pulse <= 1'b0;
      trap_code  <= 2'd0;
    end else begin
      trap_pulse <= blocked_take;
      if (blocked_take) trap_code <= cls;
    end
  end
endmodule

// File: rtl/pgate_irq.sv
module pgate_irq
  import pgate_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lvl_e          lvl,
  input  logic          cmd_valid,
  input  logic          cmd_on,
  input  logic [TW-1:0] limit,
  output logic          ie_state,
  output logic          wd_flag
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] remain;
  logic          cmd_take;
  logic [TW-1:0] load_val;

  always_comb begin
    load_val = (limit == '0) ? ONE : limit;
    unique case (lvl)
      LVL_SUPER: cmd_take = cmd_valid;
      LVL_USER1: cmd_take = cmd_valid && (cmd_on || ie_state);
      default:   cmd_take = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_state <= 1'b1;
      wd_flag  <= 1'b0;
      remain   <= '0;
    end else if (cmd_take) begin
      ie_state <= cmd_on;
      remain   <= (!cmd_on && lvl == LVL_USER1) ? load_val : '0;
      if (lvl == LVL_SUPER) wd_flag <= 1'b0;
    end else if (remain == ONE) begin
      ie_state <= 1'b1;
      wd_flag  <= 1'b1;
      remain   <= '0;
    end else if (remain != '0) begin
      remain <= remain - ONE;
    end
  end
endmodule

// File: rtl/priv_access_gate.sv
module priv_access_gate
  import pgate_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    psw_iomode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_class,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          trap_pulse,
  output logic [1:0]    trap_code,
  input  logic          ie_cmd_valid,
  input  logic          ie_cmd_on,
  input  logic [TW-1:0] ie_limit,
  output logic          ie_state,
  output logic          ie_wd_flag
);
  lvl_e lvl;
  logic permit;
  logic blocked_take;

  pgate_rules u_rules (
    .iomode (psw_iomode),
    .cls    (req_class),
    .lvl    (lvl),
    .permit (permit)
  );

  assign bus_valid    = req_valid && permit;
  assign bus_write    = req_write;
  assign bus_addr     = req_addr;
  assign bus_wdata    = req_wdata;
  assign req_ready    = permit ? bus_ready : 1'b1;
  assign rsp_rdata    = (permit && !req_write) ? bus_rdata : '0;
  assign blocked_take = req_valid && !permit;

  pgate_trap u_trap (
    .clk          (clk),
    .rst_n        (rst_n),
    .blocked_take (blocked_take),
    .cls          (req_class),
    .trap_pulse   (trap_pulse),
    .trap_code    (trap_code)
  );

  pgate_irq #(.TW(TW)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl       (lvl),
    .cmd_valid (ie_cmd_valid),
    .cmd_on    (ie_cmd_on),
    .limit     (ie_limit),
    .ie_state  (ie_state),
    .wd_flag   (ie_wd_flag)
  );
endmodule

// File: rtl/pgate_chk.sv
module pgate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] psw_iomode,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [1:0] req_class,
  input logic       bus_valid,
  input logic       rsp_nonzero,
  input logic       trap_pulse,
  input logic       ie_cmd_valid,
  input logic       ie_cmd_on,
  input logic       ie_state,
  input logic       ie_wd_flag
);
  // R2
  user0_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (psw_iomode == 2'b00 || psw_iomode == 2'b11) && req_class != 2'd0) |-> !bus_valid);

  // R5
  blocked_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bus_valid) |-> req_ready);

  // R6
  blocked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bus_valid && !req_write) |-> !rsp_nonzero);

  // R7
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> $past(req_valid && !bus_valid));

  // R8
  ie_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ie_state) |-> ($past(ie_cmd_valid) && !$past(ie_cmd_on) &&
                         $past(psw_iomode) != 2'b00 && $past(psw_iomode) != 2'b11));

  // R9
  wd_with_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ie_wd_flag) |-> $rose(ie_state));
endmodule

bind priv_access_gate pgate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .psw_iomode   (psw_iomode),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_class    (req_class),
  .bus_valid    (bus_valid),
  .rsp_nonzero  (|rsp_rdata),
  .trap_pulse   (trap_pulse),
  .ie_cmd_valid (ie_cmd_valid),
  .ie_cmd_on    (ie_cmd_on),
  .ie_state     (ie_state),
  .ie_wd_flag   (ie_wd_flag)
);

// File: tb/sim_priv_access_gate.sv
`timescale 1ns/1ps
module sim_priv_access_gate;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    psw_iomode = 2'b00;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready;
  logic [1:0]    req_class = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, rsp_rdata;
  logic          bus_valid, bus_write;
  logic          bus_ready = 1'b1;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          trap_pulse;
  logic [1:0]    trap_code;
  logic          ie_cmd_valid = 1'b0, ie_cmd_on = 1'b0;
  logic [TW-1:0] ie_limit = TW'(4);
  logic          ie_state, ie_wd_flag;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  priv_access_gate #(.AW(AW), .DW(DW), .TW(TW)) u0 (.*);

  logic [DW-1:0] tgt_mem [16];
  logic [DW-1:0] ref_mem [16];
  assign bus_rdata = tgt_mem[bus_addr[3:0]];
  always @(posedge clk)
    if (bus_valid && bus_ready && bus_write) tgt_mem[bus_addr[3:0]] <= bus_wdata;

  logic          m_trap;
  logic [1:0]    m_code;
  logic          m_ie, m_wd;
  int            m_cnt;

  function automatic int tier(input logic [1:0] f);
    return (f == 2'b01) ? 1 : (f == 2'b10) ? 2 : 0;
  endfunction

  function automatic logic allowed(input logic [1:0] f, input logic [1:0] c);
    int t = tier(f);
    if (t == 2) return 1'b1;
    if (t == 1) return c <= 2'd1;
    return c == 2'd0;
  endfunction

  function automatic string tag_for(input logic [1:0] f);
    int t = tier(f);
    return (t == 2) ? "R4" : (t == 1) ? "R3" : "R2";
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check combinational, model the edge, check registers
  task automatic step(input logic [1:0] md, input logic v, input logic w, input logic [1:0] c,
                      input logic [3:0] a, input logic [DW-1:0] d, input logic br,
                      input logic iv, input logic ion, input logic [TW-1:0] lim);
    logic ok;
    int   t;
    psw_iomode = md; req_valid = v; req_write = w; req_class = c;
    req_addr = AW'(a); req_wdata = d; bus_ready = br;
    ie_cmd_valid = iv; ie_cmd_on = ion; ie_limit = lim;
    #1;
    ok = allowed(md, c);
    chk(tag_for(md), {31'd0, bus_valid}, {31'd0, v && ok});
    chk("R5", {31'd0, req_ready}, {31'd0, ok ? br : 1'b1});
    if (v && ok) begin
      chk("R5", {31'd0, bus_write}, {31'd0, w});
      chk("R5", {16'd0, bus_addr}, {16'd0, AW'(a)});
    end
    if (v && !w) chk("R6", rsp_rdata, ok ? ref_mem[a] : '0);
    @(posedge clk);
    if (v && ok && br && w) ref_mem[a] = d;
    m_trap = v && !ok;
    if (v && !ok) m_code = c;
    t = tier(md);
    if (iv && t != 0 && !(t == 1 && !ion && !m_ie)) begin
      m_ie = ion;
      m_cnt = (!ion && t == 1) ? ((lim == 0) ? 1 : int'(lim)) : 0;
      if (t == 2) m_wd = 1'b0;
    end else if (m_cnt == 1) begin
      m_ie = 1'b1; m_wd = 1'b1; m_cnt = 0;
    end else if (m_cnt != 0) begin
      m_cnt--;
    end
    @(negedge clk);
    chk("R7", {31'd0, trap_pulse}, {31'd0, m_trap});
    chk("R7", {30'd0, trap_code}, {30'd0, m_code});
    chk(t == 0 ? "R8" : (t == 1 ? "R9" : "R10"), {31'd0, ie_state}, {31'd0, m_ie});
    chk("R9", {31'd0, ie_wd_flag}, {31'd0, m_wd});
  endtask

  task automatic idle(input logic [1:0] md, input int n);
    for (int i = 0; i < n; i++) step(md, 1'b0, 1'b0, 2'd0, 4'd0, '0, 1'b1, 1'b0, 1'b0, TW'(4));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) begin tgt_mem[i] = 32'h100 + i; ref_mem[i] = 32'h100 + i; end
    m_trap = 0; m_code = 0; m_ie = 1; m_wd = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {31'd0, ie_state}, 32'd1);
    chk("R11", {31'd0, ie_wd_flag}, 32'd0);
    chk("R7", {31'd0, trap_pulse}, 32'd0);
    chk("R7", {30'd0, trap_code}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: reserved mode acts as lowest tier; blocked write must not land
    step(2'b11, 1, 1, 2'd3, 4'd5, 32'hDEAD, 1, 0, 0, TW'(4));
    step(2'b11, 1, 0, 2'd1, 4'd5, '0, 1, 0, 0, TW'(4));
    step(2'b10, 1, 0, 2'd3, 4'd5, '0, 1, 0, 0, TW'(4));   // R6 readback
    // R3: middle tier guarded peripheral blocked, open one allowed with back-pressure
    step(2'b01, 1, 0, 2'd2, 4'd2, '0, 0, 0, 0, TW'(4));
    step(2'b01, 1, 1, 2'd1, 4'd2, 32'h55, 0, 0, 0, TW'(4));
    step(2'b01, 1, 1, 2'd1, 4'd2, 32'h55, 1, 0, 0, TW'(4));
    // R8: lowest tier cannot disable
    step(2'b00, 0, 0, 2'd0, 4'd0, '0, 1, 1, 0, TW'(4));
    idle(2'b00, 2);
    // R9: middle disable with limit 3, repeated disable does not extend
    step(2'b01, 0, 0, 2'd0, 4'd0, '0, 1, 1, 0, TW'(3));
    step(2'b01, 0, 0, 2'd0, 4'd0, '0, 1, 1, 0, TW'(3));
    idle(2'b01, 4);
    // R9: limit 0 behaves as 1
    step(2'b01, 0, 0, 2'd0, 4'd0, '0, 1, 1, 0, TW'(0));
    idle(2'b01, 2);
    // R10: supervisor disable stays, enable clears flag
    step(2'b10, 0, 0, 2'd0, 4'd0, '0, 1, 1, 0, TW'(2));
    idle(2'b10, 5);
    step(2'b10, 0, 0, 2'd0, 4'd0, '0, 1, 1, 1, TW'(2));
    // R10: middle enable stops timer
    step(2'b01, 0, 0, 2'd0, 4'd0, '0, 1, 1, 0, TW'(6));
    idle(2'b01, 2);
    step(2'b01, 0, 0, 2'd0, 4'd0, '0, 1, 1, 1, TW'(6));
    idle(2'b01, 7);

    for (int i = 0; i < 3000; i++) begin
      logic iv;
      iv = ($urandom_range(0, 15) == 0);
      step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0), 1'($urandom),
           2'($urandom), 4'($urandom), $urandom, 1'($urandom_range(0, 3) != 0),
           iv, 1'($urandom), TW'($urandom_range(0, 9)));
    end
    finish_run();
  end
endmodule